// File: doc/BRIEF.md
# Receive Sampling Delay Calibrator

This block picks the sampling delay used for serial read data that returns from an external power-management device. It has four candidate delay codes, 0 to 3, standing for 0, 2, 4 and 6 ns of added input delay. For each candidate in turn it puts the code on its delay output, waits one settle cycle, and then asks a read port for a fixed test register. A read passes when the returned word equals the known pattern 0x5AA5. A pass for code i sets bit i of a 4-bit pass mask.

After the fourth read the whole mask is looked up in a 16-entry table. The table gives the final delay code. It does not simply take the first passing code, and a mask whose passing codes do not form a usable run is rejected. A rejected mask raises a sticky fail flag and parks the delay output at code 0. A single-cycle done pulse marks the end of every calibration. A start pulse begins a new calibration while the block is idle. The delay line and the serial transport are outside this block.

Top module: `rx_skew_calibrator`

## Requirements
- R1: After reset `dly_code_o` is 0, and `done_o`, `fail_o` and `rd_req_o` are all 0.
- R2: A start pulse seen while idle tries the codes 0, 1, 2, 3 in that order. Each code appears on `dly_code_o` one cycle before `rd_req_o` rises, and it holds until that read is acknowledged.
- R3: `rd_req_o` stays high until a cycle with `rd_ack_i` high. `rd_addr_o` always carries the `TEST_ADDR` parameter.
- R4: A read passes only when `rd_data_i` equals 0x5AA5 in the acknowledge cycle. A pass for code i sets mask bit i (bit 0 = code 0).
- R5: The final code is the table lookup on the mask. The valid entries are: mask 1 gives 0, 2 gives 1, 3 gives 0, 4 gives 2, 6 gives 1, 7 gives 1, 8 gives 3, 12 gives 3, 14 gives 2, and 15 gives 1.
- R6: The masks 0, 5, 9, 10, 11 and 13 are rejected. For these, `fail_o` becomes 1 and `dly_code_o` becomes 0.
- R7: `done_o` is high for exactly one cycle, two cycles after the fourth acknowledge is sampled. The final code and fail flag are valid in that same cycle.
- R8: `fail_o` and the final `dly_code_o` hold until the next accepted start. An accepted start clears `fail_o` and sets `dly_code_o` to 0.
- R9: A start pulse that arrives while a calibration is running has no effect.
- R10: An acknowledge that arrives while idle changes neither `dly_code_o` nor `fail_o`, and it does not raise `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to begin calibration |
| rd_req_o | output | 1 | Read request for the test register, held until acknowledged |
| rd_addr_o | output | ADDR_W | Address of the test register |
| rd_ack_i | input | 1 | Read completion, one cycle |
| rd_data_i | input | DATA_W | Read data, valid with `rd_ack_i` |
| dly_code_o | output | 2 | Sampling delay code (candidate during the run, final result afterwards) |
| done_o | output | 1 | One-cycle end-of-calibration pulse |
| fail_o | output | 1 | Sticky flag: no usable delay range |

## Verification
Several properties are checked on every cycle:
- the delay code is settled one cycle before each request and holds while the request waits;
- `done_o` never lasts longer than one cycle;
- a raised fail flag always comes with code 0;
- a start during a pending read does not drop the request;
- a stray idle acknowledge leaves the outputs alone;
- every single-pass mask resolves to its own code.

Only the bench's scenarios can show the rest: the table values for all sixteen masks, the ascending trial order, the pattern comparison against a near-miss word, and the stickiness of the result across idle time. The bench runs each of these under several read latencies.

// File: rtl/rx_skew_pkg.sv
package rx_skew_pkg;
    localparam int NUM_TRIALS = 4;
    localparam int CODE_W     = $clog2(NUM_TRIALS);

    typedef logic [CODE_W-1:0]     code_t;
    typedef logic [NUM_TRIALS-1:0] mask_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_APPLY,
        ST_READ,
        ST_RESOLVE
    } phase_e;
endpackage

// File: rtl/skew_mask_decoder.sv
module skew_mask_decoder
    import rx_skew_pkg::*;
(
    input  mask_t mask_i,
    output logic  ok_o,
    output code_t code_o
);
    always_comb begin
        ok_o   = 1'b1;
        code_o = '0;
        case (mask_i)
            4'b0001: code_o = code_t'(0);
            4'b0010: code_o = code_t'(1);
            4'b0011: code_o = code_t'(0);
            4'b0100: code_o = code_t'(2);
            4'b0110: code_o = code_t'(1);
            4'b0111: code_o = code_t'(1);
            4'b1000: code_o = code_t'(3);
            4'b1100: code_o = code_t'(3);
            4'b1110: code_o = code_t'(2);
            4'b1111: code_o = code_t'(1);
            default: begin
                ok_o   = 1'b0;
                code_o = '0;
            end
        endcase
    end

    // R5
    always_comb begin
        single_pass_pick_chk: assert (($countones(mask_i) != 1) ||
                                      (ok_o && ((mask_t'(1) << code_o) == mask_i)));
    end
endmodule

// File: rtl/skew_trial_fsm.sv
module skew_trial_fsm
    import rx_skew_pkg::*;
#(
    parameter int              DATA_W       = 16,
    parameter logic [DATA_W-1:0] PASS_PATTERN = 16'h5AA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              pick_ok_i,
    input  code_t             pick_code_i,
    output mask_t             mask_o,
    output logic              rd_req_o,
    output code_t             dly_code_o,
    output logic              done_o,
    output logic              fail_o
);
    localparam code_t LAST_TRIAL = code_t'(NUM_TRIALS - 1);

    typedef struct packed {
        phase_e phase;
        code_t  trial;
        mask_t  mask;
        code_t  dly;
        logic   done;
        logic   fail;
    } regs_t;

    localparam regs_t REGS_RST = '{phase: ST_IDLE, trial: '0, mask: '0,
                                   dly: '0, done: 1'b0, fail: 1'b0};

    regs_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.phase)
            ST_IDLE: begin
                if (start_i) begin
                    d.trial = '0;
                    d.mask  = '0;
                    d.dly   = '0;
                    d.fail  = 1'b0;
                    d.phase = ST_APPLY;
                end
            end
            ST_APPLY: d.phase = ST_READ;
            ST_READ: begin
                if (rd_ack_i) begin
                    if (rd_data_i == PASS_PATTERN) begin
                        d.mask[q.trial] = 1'b1;
                    end
                    if (q.trial == LAST_TRIAL) begin
                        d.phase = ST_RESOLVE;
                    end else begin
                        d.trial = q.trial + code_t'(1);
                        d.dly   = q.trial + code_t'(1);
                        d.phase = ST_APPLY;
                    end
                end
            end
            ST_RESOLVE: begin
                d.done  = 1'b1;
                d.phase = ST_IDLE;
                d.fail  = !pick_ok_i;
                d.dly   = pick_ok_i ? pick_code_i : '0;
            end
            default: d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    assign mask_o     = q.mask;
    assign rd_req_o   = (q.phase == ST_READ);
    assign dly_code_o = q.dly;
    assign done_o     = q.done;
    assign fail_o     = q.fail;

    // R2
    code_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req_o) |-> $stable(dly_code_o));

    // R3
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o && $stable(dly_code_o));

    // R6
    fail_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (dly_code_o == '0) && !rd_req_o);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && rd_req_o && !rd_ack_i |=> rd_req_o);

    // R10
    idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == ST_IDLE) && rd_ack_i && !start_i
        |=> $stable(dly_code_o) && $stable(fail_o) && !done_o);
endmodule

// File: rtl/rx_skew_calibrator.sv
module rx_skew_calibrator #(
    parameter int                ADDR_W       = 16,
    parameter int                DATA_W       = 16,
    parameter logic [ADDR_W-1:0] TEST_ADDR    = 16'h0040,
    parameter logic [DATA_W-1:0] PASS_PATTERN = 16'h5AA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [1:0]        dly_code_o,
    output logic              done_o,
    output logic              fail_o
);
    import rx_skew_pkg::*;

    mask_t mask;
    logic  pick_ok;
    code_t pick_code;
    code_t dly_code;

    skew_trial_fsm #(
        .DATA_W      (DATA_W),
        .PASS_PATTERN(PASS_PATTERN)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .rd_ack_i   (rd_ack_i),
        .rd_data_i  (rd_data_i),
        .pick_ok_i  (pick_ok),
        .pick_code_i(pick_code),
        .mask_o     (mask),
        .rd_req_o   (rd_req_o),
        .dly_code_o (dly_code),
        .done_o     (done_o),
        .fail_o     (fail_o)
    );

    skew_mask_decoder u_dec (
        .mask_i(mask),
        .ok_o  (pick_ok),
        .code_o(pick_code)
    );

    assign rd_addr_o  = TEST_ADDR;
    assign dly_code_o = dly_code;
endmodule

// File: tb/rx_skew_calibrator_bench.sv
module rx_skew_calibrator_bench;
    localparam logic [15:0] ADDR = 16'h0040;
    localparam logic [15:0] PAT  = 16'h5AA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rd_ack_i = 1'b0;
    logic [15:0] rd_data_i = '0;
    logic        rd_req_o;
    logic [15:0] rd_addr_o;
    logic [1:0]  dly_code_o;
    logic        done_o;
    logic        fail_o;

    always #4 clk = ~clk;

    rx_skew_calibrator u_rx_skew_calibrator (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .dly_code_o(dly_code_o), .done_o(done_o), .fail_o(fail_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int tbl [16] = '{-1, 0, 1, 0, 2, -1, 1, 1, 3, -1, -1, -1, 3, -1, 2, 1};

    task automatic check_val(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 settle, 2 reading, 3 resolve
    int m_phase = 0, m_trial = 0, m_mask = 0, m_dly = 0, m_done = 0, m_fail = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_trial = 0; m_mask = 0; m_dly = 0; m_done = 0; m_fail = 0;
        end else begin
            m_done = 0;
            if (m_phase == 0) begin
                if (start_i) begin
                    m_phase = 1; m_trial = 0; m_mask = 0; m_dly = 0; m_fail = 0;
                end
            end else if (m_phase == 1) begin
                m_phase = 2;
            end else if (m_phase == 2) begin
                if (rd_ack_i) begin
                    if (rd_data_i == PAT) m_mask = m_mask | (1 << m_trial);
                    if (m_trial == 3) m_phase = 3;
                    else begin m_trial++; m_dly = m_trial; m_phase = 1; end
                end
            end else begin
                m_done = 1; m_phase = 0;
                if (tbl[m_mask] < 0) begin m_fail = 1; m_dly = 0; end
                else begin m_fail = 0; m_dly = tbl[m_mask]; end
            end
        end
        #2;
        if (!finished) begin
            check_val("R3", "rd_req_o", int'(rd_req_o), int'(m_phase == 2));
            if (rd_req_o) check_val("R3", "rd_addr_o", int'(rd_addr_o), int'(ADDR));
            check_val("R2", "dly_code_o", int'(dly_code_o), m_dly);
            check_val("R7", "done_o", int'(done_o), m_done);
            check_val("R6", "fail_o", int'(fail_o), m_fail);
        end
    end

    // read responder: the returned word depends on the delay code in use
    logic [3:0] pass_set = '0;
    int lat_cfg = 0;
    bit inject = 0;
    int wait_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            rd_ack_i = 0; wait_cnt = 0;
        end else if (rd_ack_i) begin
            rd_ack_i = 0;
        end else if (inject) begin
            rd_ack_i = 1; rd_data_i = PAT;
        end else if (rd_req_o) begin
            if (wait_cnt >= lat_cfg) begin
                rd_ack_i = 1;
                rd_data_i = pass_set[dly_code_o] ? PAT : 16'h5AA4;
                wait_cnt = 0;
            end else wait_cnt++;
        end
    end

    task automatic pulse_start();
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
    endtask

    task automatic wait_done(string req);
        int n = 0;
        while (!done_o && n < 200) begin @(negedge clk); n++; end
        check_val(req, "done seen", int'(done_o), 1);
    endtask

    task automatic run_cal(int m, int lat);
        pass_set = 4'(m); lat_cfg = lat;
        pulse_start();
        wait_done("R7");
        if (tbl[m] < 0) begin
            check_val("R6", "fail for rejected mask", int'(fail_o), 1);
            check_val("R6", "code for rejected mask", int'(dly_code_o), 0);
        end else begin
            check_val("R5", "table code", int'(dly_code_o), tbl[m]);
            check_val("R5", "no fail", int'(fail_o), 0);
        end
        @(negedge clk);
        check_val("R7", "done single cycle", int'(done_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_val("R1", "reset code", int'(dly_code_o), 0);
        check_val("R1", "reset done", int'(done_o), 0);
        check_val("R1", "reset fail", int'(fail_o), 0);
        check_val("R1", "reset req", int'(rd_req_o), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R4, R5, R6: every mask under varying read latency
        for (int m = 0; m < 16; m++) run_cal(m, m % 3);

        // R8: rejected result is sticky, then cleared by the next start
        run_cal(9, 1);
        repeat (10) @(negedge clk);
        check_val("R8", "fail held", int'(fail_o), 1);
        check_val("R8", "code held", int'(dly_code_o), 0);
        run_cal(6, 3);
        check_val("R8", "fail cleared", int'(fail_o), 0);

        // R9: a start during the run is ignored
        pass_set = 4'b1100; lat_cfg = 2;
        pulse_start();
        repeat (3) @(negedge clk);
        start_i = 1; @(negedge clk); start_i = 0;
        repeat (4) @(negedge clk);
        start_i = 1; @(negedge clk); start_i = 0;
        wait_done("R9");
        check_val("R9", "result unaffected", int'(dly_code_o), 3);

        // R10: an acknowledge while idle changes nothing
        repeat (3) @(negedge clk);
        @(posedge clk); inject = 1;
        @(posedge clk); inject = 0;
        repeat (3) @(negedge clk);
        check_val("R10", "code after idle ack", int'(dly_code_o), 3);
        check_val("R10", "fail after idle ack", int'(fail_o), 0);
        check_val("R10", "no done after idle ack", int'(done_o), 0);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule